// File: doc/BRIEF.md
# Synchronous Slave FIFO Write Master

This block drives the write side of a synchronous slave FIFO port on an external USB bridge. A local producer, for example threshold-triggered capture logic that hands over 1024-word blocks, offers 32-bit words on a valid/ready stream. The master copies each accepted word onto the bridge data bus with an active-low write strobe. It opens a bridge buffer only when the bridge reports that buffer empty. It closes the buffer in one of three ways: when the bridge's early watermark flag says the buffer is nearly full, when the producer marks an end of transfer, or when the producer goes quiet while the buffer is partly filled.

On the stream side, the master asserts `s_ready` only in its write phase. A word moves in every cycle where `s_valid` and `s_ready` are both high. While `s_ready` is low, the producer holds the same word and `s_last` stable. `s_ready` does not depend on `s_valid`, so the producer may wait for ready before it raises valid. The write strobe is a combinational copy of the handshake, so the bridge sees the write in the same cycle the word is accepted.

Closing a partial buffer uses a one-cycle active-low packet-end strobe. After any close, the master waits until the bridge has taken the buffer away (ready flag low) and returned a fresh one (ready flag high) before it writes again.

Top module: `usb_fifo_writer`

## Requirements
- R1: During and straight after reset, `s_ready` is 0, `bus_wr_n_o` is 1, `bus_pkt_end_n_o` is 1, `bus_cs_n_o` is 0 and `bus_addr_o` equals the `SOCKET` parameter (2'b00 by default).
- R2: No write occurs while `bus_rdy_i` is low. With the producer already valid, the first write begins exactly `SETUP_CYCLES`+1 cycles after `bus_rdy_i` rises, measured cycle to cycle. During every write, `bus_cs_n_o` is 0 and `bus_addr_o` is `SOCKET`.
- R3: Each stream handshake produces exactly one cycle with `bus_wr_n_o` low, carrying that word on `bus_data_o`. Words leave in acceptance order, and no write occurs without a handshake.
- R4: From the first cycle `bus_wm_n_i` is sampled low, exactly `POST_WORDS` more words are written, counting a write in that same cycle. `s_ready` then falls in the next cycle. A `BUF_WORDS`-word bridge buffer whose watermark falls at `POST_WORDS` free slots is never overrun, whatever the gaps in the stream.
- R5: A buffer closed by the watermark rule holds exactly `BUF_WORDS` words, and no packet-end strobe is issued for it.
- R6: A word accepted with `s_last` high is written with `bus_pkt_end_n_o` low in the same cycle. The exception is the word that completes the buffer under R4, which gets no packet-end strobe.
- R7: If the buffer holds at least one word and no word is accepted for `FLUSH_CYCLES` consecutive cycles, `bus_pkt_end_n_o` is pulled low with `bus_wr_n_o` high. This happens in the `FLUSH_CYCLES`-th cycle after the last write.
- R8: After a buffer is closed, no write and no packet-end strobe occur until `bus_rdy_i` has been sampled low and then high again.
- R9: `bus_pkt_end_n_o` is never low for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock shared with the bridge |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Producer has a word |
| s_ready | output | 1 | Master accepts a word this cycle |
| s_data | input | DATA_W | Producer word |
| s_last | input | 1 | Word ends a transfer; commit a short buffer |
| bus_rdy_i | input | 1 | Bridge buffer empty and ready (high) |
| bus_wm_n_i | input | 1 | Bridge watermark flag, low when `POST_WORDS` slots remain |
| bus_cs_n_o | output | 1 | Chip select, held active low |
| bus_wr_n_o | output | 1 | Write strobe, active low |
| bus_addr_o | output | 2 | FIFO socket address |
| bus_pkt_end_n_o | output | 1 | Packet-end strobe, active low |
| bus_data_o | output | DATA_W | Write data bus |

## Verification
A bridge model tracks buffer fill, raises the watermark at two free slots and drops its ready flag after each commit. It is driven with three kinds of traffic. The first is four back-to-back capture blocks, which shows that the watermark alone ends a full buffer at exactly 4096 words. The second is a stream with regular stalls, some landing inside the post-watermark window, which shows that the post-flag count tracks accepted words rather than cycles. The third is short traffic. A 10-word transfer with an end mark separates packet-end-with-data from a full close. A lone 1024-word block followed by silence exercises the timeout strobe and its exact delay. A pause just below the timeout must not flush. A full buffer whose last word carries the end mark must not emit a packet end. Holding the ready flag high for several cycles after each commit exposes any restart that skips the fall-then-rise rearm.

// File: rtl/sfw_pkg.sv
`timescale 1ns/1ps
package sfw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STREAM = 2'd2
  } wr_phase_e;
endpackage

// File: rtl/sfw_rearm.sv
`timescale 1ns/1ps
// Opens a new buffer only after the ready flag has dropped and come back
// following the previous close.
module sfw_rearm (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_i,
  input  logic idle_i,
  input  logic close_i,
  output logic start_o
);
  logic need_fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        need_fall_q <= 1'b0;
    else if (close_i)  need_fall_q <= 1'b1;
    else if (!rdy_i)   need_fall_q <= 1'b0;
  end

  assign start_o = idle_i & rdy_i & ~need_fall_q;

  // R8: a close can never be followed directly by a restart
  assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    close_i |=> !start_o);
endmodule

// File: rtl/sfw_wm_stop.sv
`timescale 1ns/1ps
// Counts the words allowed after the watermark flag is first seen low.
module sfw_wm_stop #(
  parameter int POST_WORDS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic active_i,
  input  logic wm_n_i,
  input  logic fire_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(POST_WORDS + 1);

  logic             seen_q;
  logic [CNT_W-1:0] left_q;
  logic             post;

  assign post = seen_q | ~wm_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      left_q <= CNT_W'(POST_WORDS);
    end else if (clear_i) begin
      seen_q <= 1'b0;
      left_q <= CNT_W'(POST_WORDS);
    end else if (active_i) begin
      if (!wm_n_i) seen_q <= 1'b1;
      if (fire_i && post && left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  assign last_o = active_i & fire_i & post & (left_q == CNT_W'(1));
endmodule

// File: rtl/sfw_flush_timer.sv
`timescale 1ns/1ps
// Counts idle cycles while a buffer is partly filled; fires once at the limit.
module sfw_flush_timer #(
  parameter int FLUSH_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic kick_i,
  output logic hit_o
);
  localparam int CNT_W = $clog2(FLUSH_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(FLUSH_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!en_i || kick_i)  cnt_q <= '0;
    else if (cnt_q != LIM)     cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = en_i & ~kick_i & (cnt_q == LIM);

  // R7: the flush closes the buffer, so the timer is disarmed next cycle
  assert_flush_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !en_i);
endmodule

// File: rtl/usb_fifo_writer.sv
`timescale 1ns/1ps
module usb_fifo_writer
  import sfw_pkg::*;
#(
  parameter int         DATA_W       = 32,
  parameter int         BUF_WORDS    = 4096,
  parameter int         POST_WORDS   = 2,
  parameter int         SETUP_CYCLES = 3,
  parameter int         FLUSH_CYCLES = 25000,
  parameter logic [1:0] SOCKET       = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  input  logic              bus_rdy_i,
  input  logic              bus_wm_n_i,
  output logic              bus_cs_n_o,
  output logic              bus_wr_n_o,
  output logic [1:0]        bus_addr_o,
  output logic              bus_pkt_end_n_o,
  output logic [DATA_W-1:0] bus_data_o
);
  localparam int FILL_W = $clog2(BUF_WORDS + 1);
  localparam int SET_W  = $clog2(SETUP_CYCLES + 1);

  wr_phase_e         phase_q, phase_d;
  logic [SET_W-1:0]  setup_q;
  logic [FILL_W-1:0] fill_q;

  logic start, fire, full_close, last_pkt, flush, close_now;
  logic streaming;

  assign streaming = (phase_q == PH_STREAM);
  assign s_ready   = streaming;
  assign fire      = s_valid & s_ready;

  sfw_rearm u_rearm (
    .clk     (clk),
    .rst_n   (rst_n),
    .rdy_i   (bus_rdy_i),
    .idle_i  (phase_q == PH_IDLE),
    .close_i (close_now),
    .start_o (start)
  );

  sfw_wm_stop #(.POST_WORDS(POST_WORDS)) u_wm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start),
    .active_i (streaming),
    .wm_n_i   (bus_wm_n_i),
    .fire_i   (fire),
    .last_o   (full_close)
  );

  sfw_flush_timer #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_flush (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (streaming && fill_q != '0),
    .kick_i (fire),
    .hit_o  (flush)
  );

  assign last_pkt  = fire & s_last & ~full_close;
  assign close_now = full_close | last_pkt | flush;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (start) phase_d = PH_SETUP;
      PH_SETUP:  if (setup_q == SET_W'(SETUP_CYCLES - 1)) phase_d = PH_STREAM;
      PH_STREAM: if (close_now) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      setup_q <= '0;
      fill_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_SETUP) setup_q <= setup_q + 1'b1;
      else                     setup_q <= '0;
      if (start)     fill_q <= '0;
      else if (fire) fill_q <= fill_q + 1'b1;
    end
  end

  assign bus_cs_n_o      = 1'b0;
  assign bus_addr_o      = SOCKET;
  assign bus_wr_n_o      = ~fire;
  assign bus_data_o      = s_data;
  assign bus_pkt_end_n_o = ~(last_pkt | flush);

  // R4: a write never lands when the buffer already holds BUF_WORDS words
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (fill_q < FILL_W'(BUF_WORDS)));

  // R4: once the post-watermark words are spent, the stream is stopped
  assert_wm_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full_close |=> !s_ready);

  // R9: packet end is a single-cycle pulse
  assert_pkt_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_pkt_end_n_o |=> bus_pkt_end_n_o);

  // R2: the write phase is entered only through the setup wait
  assert_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_ready) |-> $past(phase_q == PH_SETUP));
endmodule

// File: tb/usb_fifo_writer_tb_top.sv
`timescale 1ns/1ps
module usb_fifo_writer_tb_top;
  localparam int DW    = 32;
  localparam int BUF   = 4096;
  localparam int POST  = 2;
  localparam int SETUP = 3;
  localparam int FLUSH = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_ready;
  logic rdy, wm_n;
  logic cs_n, wr_n, pkt_n;
  logic [1:0] addr;
  logic [DW-1:0] bdata;

  always #2 clk = ~clk;

  usb_fifo_writer #(
    .DATA_W(DW), .BUF_WORDS(BUF), .POST_WORDS(POST),
    .SETUP_CYCLES(SETUP), .FLUSH_CYCLES(FLUSH), .SOCKET(2'b00)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .bus_rdy_i(rdy), .bus_wm_n_i(wm_n),
    .bus_cs_n_o(cs_n), .bus_wr_n_o(wr_n), .bus_addr_o(addr),
    .bus_pkt_end_n_o(pkt_n), .bus_data_o(bdata)
  );

  int vectors = 0, miscompares = 0;
  logic [DW-1:0] exp_q[$];
  int exp_size[$];
  int exp_kind[$];   // 0 full, 1 packet end with word, 2 packet end alone

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // ---------------- bridge model ----------------
  int phase, pcnt, fill, nf, kind;
  int hold_len = 6, drain_len = 20;
  assign wm_n = ((BUF - fill) > POST);

  task automatic commit(int size, int k);
    string req;
    req = (k == 0) ? "R5" : ((k == 1) ? "R6" : "R7");
    if (exp_size.size() == 0) check(0, req, "unexpected buffer commit", size, 0);
    else begin
      int es, ek;
      es = exp_size.pop_front();
      ek = exp_kind.pop_front();
      check(size == es, req, "buffer word count", size, es);
      check(k == ek, req, "buffer close kind", k, ek);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      phase <= 2; pcnt <= 10; fill <= 0; rdy <= 1'b0;
    end else begin
      case (phase)
        0: begin
          nf = fill + (wr_n ? 0 : 1);
          if (!wr_n && fill >= BUF) check(0, "R4", "overflow write", fill + 1, BUF);
          if (!pkt_n || nf == BUF) begin
            kind = !pkt_n ? (!wr_n ? 1 : 2) : 0;
            commit(nf, kind);
            phase <= 1; pcnt <= hold_len;
          end
          fill <= nf;
        end
        1: begin
          if (!wr_n || !pkt_n) check(0, "R8", "activity before rearm", {wr_n, pkt_n}, 3);
          if (pcnt == 0) begin phase <= 2; pcnt <= drain_len; rdy <= 1'b0; end
          else pcnt <= pcnt - 1;
        end
        default: begin
          if (!wr_n || !pkt_n) check(0, "R2", "activity while ready low", {wr_n, pkt_n}, 3);
          if (pcnt == 0) begin phase <= 0; fill <= 0; rdy <= 1'b1; end
          else pcnt <= pcnt - 1;
        end
      endcase
    end
  end

  // ---------------- scoreboard monitor ----------------
  int ncyc = 0, t_open = 0, last_wr = 0;
  bit rdy_prev = 1'b0, setup_probe = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      ncyc++;
      if (rdy && !rdy_prev) t_open = ncyc;
      rdy_prev = rdy;
      if (!wr_n) begin
        if (exp_q.size() == 0) check(0, "R3", "write without handshake", bdata, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(bdata == e, "R3", "write data", bdata, e);
        end
        check(cs_n == 1'b0 && addr == 2'b00, "R2", "select/address during write", {cs_n, addr}, 0);
        if (setup_probe) begin
          check(ncyc - t_open == SETUP + 1, "R2", "setup delay", ncyc - t_open, SETUP + 1);
          setup_probe = 1'b0;
        end
        last_wr = ncyc;
      end
      if (!pkt_n && wr_n)
        check(ncyc - last_wr == FLUSH, "R7", "flush delay", ncyc - last_wr, FLUSH);
    end
  end

  // ---------------- driver ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(int n, int base, bit last_end, int gap_every, int gap_len);
    for (int i = 0; i < n; i++) begin
      if (gap_every > 0 && i > 0 && (i % gap_every) == 0) begin
        s_valid = 1'b0;
        repeat (gap_len) tick();
      end
      exp_q.push_back(DW'(base + i));
      s_valid = 1'b1;
      s_data  = DW'(base + i);
      s_last  = last_end && (i == n - 1);
      while (!s_ready) tick();
      tick();
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic expect_buf(int size, int k);
    exp_size.push_back(size);
    exp_kind.push_back(k);
  endtask

  task automatic wait_buffers();
    while (exp_size.size() != 0) tick();
    repeat (3) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "WD", "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(s_ready == 1'b0, "R1", "s_ready in reset", s_ready, 0);
    check(wr_n == 1'b1, "R1", "write strobe in reset", wr_n, 1);
    check(pkt_n == 1'b1, "R1", "packet end in reset", pkt_n, 1);
    check(cs_n == 1'b0, "R1", "chip select in reset", cs_n, 0);
    check(addr == 2'b00, "R1", "address in reset", addr, 0);
    tick();
    rst_n = 1'b1;
    @(negedge clk);
    check(s_ready == 1'b0 && wr_n == 1'b1, "R1", "idle after reset", {s_ready, wr_n}, 1);

    // R2, R4, R5: four back-to-back capture blocks, valid held before ready rises
    setup_probe = 1'b1;
    expect_buf(BUF, 0);
    tick();
    send(BUF, 32'h0100_0000, 1'b0, 0, 0);

    // R8, R4, R5: stalls every 7 words; restart must wait for a fresh ready
    setup_probe = 1'b1;
    expect_buf(BUF, 0);
    send(BUF, 32'h0200_0000, 1'b0, 7, 3);
    wait_buffers();
    check(setup_probe == 1'b0, "R2", "setup probe consumed", setup_probe, 0);

    // R6, R9: short transfer closed by end mark
    expect_buf(10, 1);
    send(10, 32'h0300_0000, 1'b1, 0, 0);
    wait_buffers();

    // R7, R9: lone capture block then silence
    expect_buf(1024, 2);
    send(1024, 32'h0400_0000, 1'b0, 0, 0);
    wait_buffers();

    // R7: pause just under the timeout must not flush
    expect_buf(10, 1);
    send(5, 32'h0500_0000, 1'b0, 0, 0);
    repeat (FLUSH - 5) tick();
    send(5, 32'h0500_0005, 1'b1, 0, 0);
    wait_buffers();

    // R6, R5: end mark on the buffer-completing word gives no packet end
    expect_buf(BUF, 0);
    send(BUF, 32'h0600_0000, 1'b1, 0, 0);
    wait_buffers();

    check(exp_q.size() == 0, "R3", "words never written", exp_q.size(), 0);
    check(exp_size.size() == 0, "R5", "buffers never committed", exp_size.size(), 0);
    report();
    $finish;
  end
endmodule